// File: doc/BRIEF.md
# Effective Address Generator with Pointer Fetch

This block turns an addressing-mode code plus its operand bytes and the two index registers into the final 16-bit operand address of an 8-bit processor. A single start strobe launches one computation. Modes that need only arithmetic finish one cycle after the strobe is taken. The pointer-based modes first read a 16-bit little-endian pointer through a byte-wide memory read port and finish four cycles after the strobe is taken. The immediate mode produces no address and hands the operand byte back as the value.

The surrounding core samples `eff_addr`, `page_crossed`, `imm_valid` and `imm_value` in the cycle `done` is high. These outputs hold their values until the next completion. The memory port returns read data exactly one cycle after a request and has no stall. While a pointer fetch is in progress, start strobes are dropped.

Top module: `eff_addr_gen`

## Requirements
- R1: While reset is low at a clock edge, `done`, `mem_rd`, `page_crossed` and `imm_valid` are 0 after that edge, and `eff_addr` and `imm_value` are 0.
- R2: The mode codes are 0 immediate, 1 zero page, 2 zero page + X, 3 absolute, 4 absolute + X, 5 absolute + Y, 6 pre-indexed pointer (X), 7 post-indexed pointer (Y) and 8 indirect jump. For mode 0, `done` is high in the cycle after the strobe is taken, `imm_valid` is 1, `imm_value` equals `opnd_lo`, `eff_addr` is 0, and no memory read is made.
- R3: Mode 1 gives `{8'h00, opnd_lo}`. Mode 2 gives `{8'h00, (opnd_lo + idx_x) mod 256}`. Both complete one cycle after the strobe, with `page_crossed` at 0.
- R4: Modes 3, 4 and 5 give `({opnd_hi, opnd_lo} + k) mod 65536`, where k is 0, `idx_x` or `idx_y` respectively. They complete one cycle after the strobe.
- R5: For modes 4 and 5, `page_crossed` is 1 exactly when `opnd_lo` plus the index exceeds 255.
- R6: Mode 6 reads from `{8'h00, b}` and then from `{8'h00, (b+1) mod 256}`, where b = `(opnd_lo + idx_x) mod 256`. The result is the pointer {second byte, first byte}, with `page_crossed` 0.
- R7: Mode 7 reads from `{8'h00, opnd_lo}` and then from `{8'h00, (opnd_lo+1) mod 256}`. The result is `(pointer + idx_y) mod 65536`. `page_crossed` is 1 exactly when the pointer low byte plus `idx_y` exceeds 255.
- R8: Mode 8 reads from `{opnd_hi, opnd_lo}` and then from `{opnd_hi, (opnd_lo+1) mod 256}`, so that a low byte at offset 0xFF takes its high byte from offset 0x00 of the same page. The result is the pointer, with `page_crossed` 0.
- R9: For the pointer modes, `mem_rd` is high in the first and second cycles after the strobe is taken, with the low-byte address and then the high-byte address. It is low in the third. `done` rises in the fourth.
- R10: `done` is high for one cycle per computation. A strobe arriving while a pointer fetch is in progress, from the cycle after the strobe is taken up to and including the third cycle, is ignored. A strobe in the `done` cycle is accepted. Result outputs change only at a completion.
- R11: Codes 9 to 15 behave as absolute mode 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a computation when idle |
| mode | input | 4 | Addressing-mode code |
| opnd_lo | input | 8 | First operand byte (low address or immediate value) |
| opnd_hi | input | 8 | Second operand byte (high address) |
| idx_x | input | 8 | X index register value |
| idx_y | input | 8 | Y index register value |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| done | output | 1 | Result valid pulse |
| eff_addr | output | 16 | Effective address |
| page_crossed | output | 1 | Index addition carried into the high byte |
| imm_valid | output | 1 | Last result was an immediate value |
| imm_value | output | 8 | Immediate value |

## Verification
Two functions can meet in one cycle. The completion pulse of one computation can coincide with the acceptance of the next strobe, and a dropped strobe can arrive in the middle of a pointer fetch. The bench holds `start` high across whole pointer fetches and changes the mode in every cycle. It also issues arithmetic modes back to back, with the strobe placed in each `done` cycle. A cycle-level reference model decides which strobes are taken, and the bench compares `done`, the memory requests and every result output against it in every cycle.

// File: rtl/eag_pkg.sv
// Package: shared types for the effective address generator.
// Assumes a 4-bit mode code; codes above the jump mode are handled as absolute.
package eag_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MD_IMM  = 4'd0,
        MD_ZP   = 4'd1,
        MD_ZPX  = 4'd2,
        MD_ABS  = 4'd3,
        MD_ABSX = 4'd4,
        MD_ABSY = 4'd5,
        MD_INDX = 4'd6,
        MD_INDY = 4'd7,
        MD_JIND = 4'd8
    } amode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LO,
        SQ_HI,
        SQ_END
    } seq_state_e;

    // True for modes that fetch a pointer from memory
    function automatic logic needs_ptr(input logic [MODE_W-1:0] m);
        return (m == MD_INDX) || (m == MD_INDY) || (m == MD_JIND);
    endfunction

    // True for modes whose result lies in page zero
    function automatic logic zp_result(input logic [MODE_W-1:0] m);
        return (m == MD_ZP) || (m == MD_ZPX);
    endfunction

endpackage

// File: rtl/eag_index_add.sv
// Module: adds an index byte to a two-byte base.
// Reports the carry out of the low byte so that callers can flag a page crossing.
// Purely combinational; callers truncate the sum when they need page-zero wrap.
module eag_index_add #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]   base_lo,
    input  logic [DATA_W-1:0]   base_hi,
    input  logic [DATA_W-1:0]   idx,
    output logic [2*DATA_W-1:0] sum,
    output logic                carry
);

    logic [DATA_W:0] lo_ext;

    // Low-byte add with carry, then ripple the carry into the high byte
    always_comb begin
        lo_ext = {1'b0, base_lo} + {1'b0, idx};
        carry  = lo_ext[DATA_W];
        sum    = {base_hi + {{(DATA_W-1){1'b0}}, carry}, lo_ext[DATA_W-1:0]};
    end

endmodule

// File: rtl/eag_ptr_seq.sv
// Module: fetches a little-endian pointer with two byte reads.
// The second read stays in the page of the first, and its offset wraps from 0xFF to 0x00.
// Assumes read data arrives exactly one cycle after each request, with no stall.
// ptr_valid marks the single cycle in which ptr_word holds both bytes.
module eag_ptr_seq
    import eag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [DATA_W-1:0]   ptr_page,
    input  logic [DATA_W-1:0]   ptr_base,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                mem_rd,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic                busy,
    output logic                ptr_valid,
    output logic [2*DATA_W-1:0] ptr_word
);

    localparam int              ADDR_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};

    seq_state_e        state;
    logic [DATA_W-1:0] page_q;
    logic [DATA_W-1:0] base_q;
    logic [DATA_W-1:0] lo_q;

    // Step through the low read, the high read and the hand-over cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            page_q <= '0;
            base_q <= '0;
            lo_q   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (launch) begin
                        state  <= SQ_LO;
                        page_q <= ptr_page;
                        base_q <= ptr_base;
                    end
                end
                SQ_LO:   state <= SQ_HI;
                SQ_HI: begin
                    lo_q  <= mem_rdata;
                    state <= SQ_END;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Drive the read port and present the assembled pointer
    always_comb begin
        mem_rd    = (state == SQ_LO) || (state == SQ_HI);
        mem_addr  = {page_q, (state == SQ_HI) ? (base_q + ONE) : base_q};
        busy      = (state != SQ_IDLE);
        ptr_valid = (state == SQ_END);
        ptr_word  = {mem_rdata, lo_q};
    end

    // High-byte read stays in the same page at the next offset (R8 page wrap)
    p_hi_same_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_HI) |->
            (mem_addr[ADDR_W-1:DATA_W] == $past(mem_addr[ADDR_W-1:DATA_W])) &&
            (mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0]) + ONE));

    // Exactly two consecutive reads, then the pointer is handed over (R9)
    p_two_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |=> mem_rd ##1 (!mem_rd && ptr_valid));

endmodule

// File: rtl/eff_addr_gen.sv
// Module: effective address generator, the top level.
// Arithmetic modes finish one cycle after the strobe is taken.
// Pointer modes launch eag_ptr_seq and finish after the fetched pointer is indexed.
// Assumes the operands and index registers are valid in the cycle the strobe is taken.
// Strobes are dropped while a fetch is in progress.
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [MODE_W-1:0]      mode,
    input  logic [DATA_W-1:0]      opnd_lo,
    input  logic [DATA_W-1:0]      opnd_hi,
    input  logic [DATA_W-1:0]      idx_x,
    input  logic [DATA_W-1:0]      idx_y,
    output logic                   mem_rd,
    output logic [2*DATA_W-1:0]    mem_addr,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic                   done,
    output logic [2*DATA_W-1:0]    eff_addr,
    output logic                   page_crossed,
    output logic                   imm_valid,
    output logic [DATA_W-1:0]      imm_value
);

    localparam int ADDR_W = 2 * DATA_W;

    logic                accept;
    logic                launch;
    logic                seq_busy;
    logic                ptr_valid;
    logic [ADDR_W-1:0]   ptr_word;
    logic [DATA_W-1:0]   dir_idx;
    logic [DATA_W-1:0]   dir_hi;
    logic [ADDR_W-1:0]   dir_sum;
    logic                dir_carry;
    logic [ADDR_W-1:0]   dir_addr;
    logic                dir_cross;
    logic [DATA_W-1:0]   ptr_page;
    logic [DATA_W-1:0]   ptr_base;
    logic [MODE_W-1:0]   mode_q;
    logic [DATA_W-1:0]   y_q;
    logic [DATA_W-1:0]   fin_idx;
    logic [ADDR_W-1:0]   fin_sum;
    logic                fin_carry;

    // A strobe counts only while no fetch is running
    always_comb begin
        accept = start && !seq_busy;
        launch = accept && needs_ptr(mode);
    end

    // Choose the index and the high byte for the one-cycle path and the pre-index
    always_comb begin
        case (mode)
            MD_ZPX, MD_ABSX, MD_INDX: dir_idx = idx_x;
            MD_ABSY:                  dir_idx = idx_y;
            default:                  dir_idx = '0;
        endcase
        dir_hi = zp_result(mode) ? '0 : opnd_hi;
    end

    eag_index_add #(.DATA_W(DATA_W)) u_dir_add (
        .base_lo (opnd_lo),
        .base_hi (dir_hi),
        .idx     (dir_idx),
        .sum     (dir_sum),
        .carry   (dir_carry)
    );

    // Form the one-cycle result and the pointer location for the fetch modes
    always_comb begin
        dir_addr  = dir_sum;
        dir_cross = 1'b0;
        ptr_page  = '0;
        ptr_base  = opnd_lo;
        case (mode)
            MD_IMM:           dir_addr  = '0;
            MD_ZP, MD_ZPX:    dir_addr  = {{DATA_W{1'b0}}, dir_sum[DATA_W-1:0]};
            MD_ABSX, MD_ABSY: dir_cross = dir_carry;
            MD_INDX:          ptr_base  = dir_sum[DATA_W-1:0];
            MD_JIND:          ptr_page  = opnd_hi;
            default:          dir_cross = 1'b0;
        endcase
    end

    eag_ptr_seq #(.DATA_W(DATA_W)) u_ptr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .ptr_page  (ptr_page),
        .ptr_base  (ptr_base),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .busy      (seq_busy),
        .ptr_valid (ptr_valid),
        .ptr_word  (ptr_word)
    );

    // Post-index only in the Y pointer mode
    always_comb fin_idx = (mode_q == MD_INDY) ? y_q : '0;

    eag_index_add #(.DATA_W(DATA_W)) u_fin_add (
        .base_lo (ptr_word[DATA_W-1:0]),
        .base_hi (ptr_word[ADDR_W-1:DATA_W]),
        .idx     (fin_idx),
        .sum     (fin_sum),
        .carry   (fin_carry)
    );

    // Capture the mode and Y for the fetch; register results and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q       <= '0;
            y_q          <= '0;
            done         <= 1'b0;
            eff_addr     <= '0;
            page_crossed <= 1'b0;
            imm_valid    <= 1'b0;
            imm_value    <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                mode_q <= mode;
                y_q    <= idx_y;
            end
            if (ptr_valid) begin
                done         <= 1'b1;
                eff_addr     <= fin_sum;
                page_crossed <= (mode_q == MD_INDY) && fin_carry;
                imm_valid    <= 1'b0;
            end else if (accept && !needs_ptr(mode)) begin
                done         <= 1'b1;
                eff_addr     <= dir_addr;
                page_crossed <= dir_cross;
                imm_valid    <= (mode == MD_IMM);
                if (mode == MD_IMM) begin
                    imm_value <= opnd_lo;
                end
            end
        end
    end

    // Page-zero modes never leave page zero (R3)
    p_zp_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zp_result(mode_q)) |-> (eff_addr[ADDR_W-1:DATA_W] == '0));

    // Immediate completes straight from a strobe with no read in flight (R2)
    p_imm_nomem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && imm_valid) |-> ($past(start) && !mem_rd));

    // Only indexed-absolute and Y-pointer results may flag a crossing (R5)
    p_cross_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && page_crossed) |->
            ((mode_q == MD_ABSX) || (mode_q == MD_ABSY) || (mode_q == MD_INDY)));

    // A strobe during a fetch leaves the captured mode untouched (R10)
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && seq_busy) |=> (mode_q == $past(mode_q)));

endmodule

// File: tb/eff_addr_gen_tb_top.sv
// Bench: a cycle-level reference model compared with the DUT on every clock.
module eff_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        done, page_crossed, imm_valid;
    logic [15:0] eff_addr;
    logic [7:0]  imm_value;

    int checks = 0;
    int fails  = 0;
    bit chk_en = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    eff_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .done(done), .eff_addr(eff_addr), .page_crossed(page_crossed),
        .imm_valid(imm_valid), .imm_value(imm_value)
    );

    // Memory contents, computed from the address
    function automatic logic [7:0] memf(input int a);
        logic [15:0] w;
        w = 16'(a);
        return 8'((w[7:0] * 8'd7)) ^ w[15:8] ^ 8'hA5;
    endfunction

    // One-cycle read latency
    always @(posedge clk) if (mem_rd) mem_rdata <= memf(int'(mem_addr));

    // Reference model state
    int m_cnt = 0, m_mode = 0, m_pa0 = 0, m_pa1 = 0, m_y = 0;
    int e_eff = 0, e_ival = 0;
    bit e_done = 0, e_pc = 0, e_iv = 0;

    function automatic string req_for(input int md);
        case (md)
            0:       return "R2";
            1, 2:    return "R3";
            3, 4, 5: return "R4";
            6:       return "R6";
            7:       return "R7";
            8:       return "R8";
            default: return "R11";
        endcase
    endfunction

    always @(posedge clk) begin
        int lo, hi, ptr, base;
        if (!rst_n) begin
            m_cnt = 0; e_done = 0; e_eff = 0; e_pc = 0; e_iv = 0; e_ival = 0;
        end else begin
            e_done = 0;
            if (m_cnt == 3) begin
                lo = memf(m_pa0); hi = memf(m_pa1); ptr = hi * 256 + lo;
                if (m_mode == 7) begin
                    e_eff = (ptr + m_y) % 65536; e_pc = ((lo + m_y) > 255);
                end else begin
                    e_eff = ptr; e_pc = 0;
                end
                e_iv = 0; e_done = 1; m_cnt = 0;
            end else if (m_cnt != 0) begin
                m_cnt = m_cnt + 1;
            end else if (start) begin
                m_mode = int'(mode);
                base = int'(opnd_hi) * 256 + int'(opnd_lo);
                case (m_mode)
                    0: begin e_iv = 1; e_ival = int'(opnd_lo); e_eff = 0; e_pc = 0; e_done = 1; end
                    1: begin e_iv = 0; e_eff = int'(opnd_lo); e_pc = 0; e_done = 1; end
                    2: begin e_iv = 0; e_eff = (int'(opnd_lo) + int'(idx_x)) % 256; e_pc = 0; e_done = 1; end
                    4: begin e_iv = 0; e_eff = (base + int'(idx_x)) % 65536;
                             e_pc = ((int'(opnd_lo) + int'(idx_x)) > 255); e_done = 1; end
                    5: begin e_iv = 0; e_eff = (base + int'(idx_y)) % 65536;
                             e_pc = ((int'(opnd_lo) + int'(idx_y)) > 255); e_done = 1; end
                    6: begin m_pa0 = (int'(opnd_lo) + int'(idx_x)) % 256;
                             m_pa1 = (m_pa0 + 1) % 256; m_cnt = 1; end
                    7: begin m_pa0 = int'(opnd_lo); m_pa1 = (m_pa0 + 1) % 256;
                             m_y = int'(idx_y); m_cnt = 1; end
                    8: begin m_pa0 = base;
                             m_pa1 = int'(opnd_hi) * 256 + (int'(opnd_lo) + 1) % 256; m_cnt = 1; end
                    default: begin e_iv = 0; e_eff = base; e_pc = 0; e_done = 1; end
                endcase
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output away from the active edge
    always @(negedge clk) begin
        string rq;
        bit    e_rd;
        if (chk_en) begin
            rq   = !rst_n ? "R1" : req_for(m_mode);
            e_rd = (m_cnt == 1) || (m_cnt == 2);
            chk(!rst_n ? "R1" : "R10", "done", int'(done), int'(e_done));
            chk(!rst_n ? "R1" : "R9", "mem_rd", int'(mem_rd), int'(e_rd));
            if (e_rd && rst_n)
                chk(rq, "mem_addr", int'(mem_addr), (m_cnt == 1) ? m_pa0 : m_pa1);
            chk(rq, "eff_addr", int'(eff_addr), e_eff);
            chk(!rst_n ? "R1" : ((m_mode == 7) ? "R7" : "R5"), "page_crossed",
                int'(page_crossed), int'(e_pc));
            chk(!rst_n ? "R1" : "R2", "imm_valid", int'(imm_valid), int'(e_iv));
            chk(!rst_n ? "R1" : "R2", "imm_value", int'(imm_value), e_ival);
        end
    end

    task automatic issue(input int md, input int lo, input int hi, input int x, input int y);
        @(negedge clk);
        start = 1'b1; mode = 4'(md); opnd_lo = 8'(lo); opnd_hi = 8'(hi);
        idx_x = 8'(x); idx_y = 8'(y);
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        int s;
        @(posedge clk);
        chk_en = 1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R2 immediate, R3 page zero, R4/R5 absolute, R11 unused codes
        issue(0, 'h3C, 'h99, 1, 2);
        issue(1, 'h80, 'h12, 0, 0);
        issue(2, 'hF0, 'h12, 'h20, 0);
        issue(3, 'h34, 'h12, 5, 5);
        issue(4, 'hF0, 'h12, 'h20, 0);
        issue(5, 'h00, 'h12, 0, 5);
        issue(4, 'hF0, 'hFF, 'h20, 0);
        issue(12, 'h78, 'h56, 9, 9);
        // R6 pre-index with wrap, R7 post-index, R8 jump page bug
        issue(6, 'hFE, 0, 1, 0);
        issue(6, 'h10, 0, 5, 0);
        issue(7, 'hFF, 0, 0, 'h80);
        issue(7, 'h40, 0, 0, 'hFF);
        issue(8, 'hFF, 'h12, 0, 0);
        issue(8, 'h80, 'h12, 0, 0);
        // R10: strobe held through a fetch with changing modes, then back-to-back arithmetic
        @(negedge clk);
        start = 1'b1; mode = 4'd7; opnd_lo = 8'h22; idx_y = 8'hE0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            mode = 4'(1 + (i % 5)); opnd_lo = 8'(i * 37); idx_x = 8'(i * 91);
        end
        start = 1'b0;
        repeat (6) @(negedge clk);
        // Sweep of generated operands over all modes
        s = 1;
        for (int i = 0; i < 160; i++) begin
            s = (s * 1103 + 12345) % 65521;
            issue(i % 16, s % 256, (s / 256) % 256, (s * 3) % 256, (s * 5) % 256);
        end
        repeat (4) @(negedge clk);
        finished = 1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

endmodule